// File: doc/BRIEF.md
# Vicinity Tag Response Frame Encoder

This block turns a tag-to-reader response into a per-tick modulation enable. A response is requested with a one-cycle strobe that carries the byte count, a slow-mode flag and the tick at which the reader's command ended. The data bytes then arrive over a valid/ready byte port. The encoder builds a stream of half-bit symbols. It starts with a fixed start-of-frame pattern, follows with two symbols per data bit, and closes with a fixed end-of-frame pattern. It drives one enable bit per tick of a free-running counter. The counter advances once per clock, and each clock is one subcarrier-rate tick.

The response is scheduled from the reader's end-of-frame tick. The block adds a fixed turnaround and removes a one-tick output register delay. The result may fall on any tick. The encoder starts on the eight-tick group boundary at or below that tick and pushes the symbol stream later by the remainder, so the first symbol leaves exactly on the computed tick. The last group is padded with zeros. In slow mode every symbol lasts four times longer.

Top module: `vtag_resp_encoder`

## Requirements
- R1: After reset, `mod_out`, `busy` and `byte_ready` are all 0.
- R2: An accepted request sets S = `reader_eof_tick` + 131 (turnaround 132 minus one tick of output delay) and A = S with its low three bits cleared. At the first clock edge where `now_tick` has reached A, `busy` rises. The comparison is taken as the signed difference modulo 2^32. `busy` and `mod_out` are registered, so they first show the frame in the cycle after that edge.
- R3: A data bit is two half-bit symbols. Bit value 1 is sent as symbol 0 then 1, and bit value 0 as 1 then 0. Symbol 1 means `mod_out` = 1. Bits of a byte go out least significant first, and bytes go out in the order they are accepted.
- R4: The first 8 symbols of a frame are 0,0,0,1,1,1,0,1. After the last data bit come the 8 symbols 1,0,1,1,1,0,0,0.
- R5: Each symbol lasts 8 ticks. Let d = S mod 8. `mod_out` is 0 for the first d ticks of the frame, then carries the symbol stream, then is 0 for 8 - d ticks. `busy` is therefore high for exactly (16 + 16·len)·8 + 8 ticks.
- R6: With `frame_slow` = 1, each symbol lasts 32 ticks. Busy then lasts (16 + 16·len)·32 + 8 ticks, and the leading d and trailing 8 - d zero ticks are unchanged.
- R7: `mod_out` is 0 in every cycle in which `busy` is 0.
- R8: A `frame_start` is ignored while a frame is pending or `busy` is high. No second frame follows, and no extra bytes are requested.
- R9: `byte_ready` is raised only for an accepted frame and only until `frame_len` bytes have been taken. A length of 0 yields start-of-frame and end-of-frame only.
- R10: Scheduling is correct when A lies past the wrap of the 32-bit tick counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_tick | input | 32 | Free-running tick counter value |
| frame_start | input | 1 | One-cycle response request |
| frame_len | input | 6 | Number of data bytes in the response |
| frame_slow | input | 1 | Four-times symbol duration |
| reader_eof_tick | input | 32 | Tick at which the reader's command ended |
| byte_valid | input | 1 | Data byte offered |
| byte_data | input | 8 | Data byte |
| byte_ready | output | 1 | Encoder takes the offered byte |
| mod_out | output | 1 | Modulation enable for the current tick |
| busy | output | 1 | A frame is being output |

## Verification
The collision that matters is a new request arriving while the encoder is still emitting a frame. The bench provokes it by raising `frame_start` in the middle of a long frame, with a different length and reader time. It judges the result by three things. The running waveform must match its model tick for tick. No further busy period may follow. `byte_ready` must stay low. A second overlap occurs in every frame: byte fetches happen while symbols are being output. A sweep over all eight start offsets, both speeds and several lengths compares each tick of `mod_out` against a model computed arithmetically. One scheduled start straddles the counter wrap.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

  localparam logic [7:0] OPEN_PAT  = 8'h1D;
  localparam logic [7:0] CLOSE_PAT = 8'hB8;

  typedef enum logic [1:0] {
    SEG_OPEN,
    SEG_DATA,
    SEG_CLOSE,
    SEG_END
  } seg_e;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_BODY,
    PH_TAIL
  } phase_e;

  // Half-bit symbol of a data bit: 1 -> (0,1), 0 -> (1,0)
  function automatic logic data_half(input logic bitv, input logic second);
    return second ? bitv : ~bitv;
  endfunction

  // Framing patterns go out most significant symbol first
  function automatic logic pat_half(input logic [7:0] pat, input logic [2:0] idx);
    return pat[3'd7 - idx];
  endfunction

endpackage

// File: rtl/rfe_sched.sv
module rfe_sched #(
  parameter int TICK_W     = 32,
  parameter int TURNAROUND = 132,
  parameter int PIPE_DLY   = 1,
  parameter int GRP_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [TICK_W-1:0] eof_tick,
  input  logic [TICK_W-1:0] now_tick,
  output logic              launch,
  output logic              pending,
  output logic [GRP_W-1:0]  delay_now,
  output logic [TICK_W-1:0] aligned
);

  localparam logic [TICK_W-1:0] GRP_MASK = {{(TICK_W-GRP_W){1'b1}}, {GRP_W{1'b0}}};

  function automatic logic [TICK_W-1:0] start_of(input logic [TICK_W-1:0] eof);
    return eof + TICK_W'(TURNAROUND) - TICK_W'(PIPE_DLY);
  endfunction

  logic [TICK_W-1:0] start_now;
  logic [TICK_W-1:0] diff;
  logic              pend_q;
  logic [TICK_W-1:0] aligned_q;

  assign start_now = start_of(eof_tick);
  assign delay_now = start_now[GRP_W-1:0];
  assign diff      = now_tick - aligned_q;
  assign launch    = pend_q && !diff[TICK_W-1];
  assign pending   = pend_q;
  assign aligned   = aligned_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      aligned_q <= '0;
    end else if (accept) begin
      pend_q    <= 1'b1;
      aligned_q <= start_now & GRP_MASK;
    end else if (launch) begin
      pend_q    <= 1'b0;
    end
  end

endmodule

// File: rtl/rfe_symgen.sv
module rfe_symgen
  import rfe_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             adv,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             byte_ready,
  output logic             sym,
  output logic             sym_last
);

  seg_e             seg_q;
  logic [3:0]       pos_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] fetched_q;
  logic [LEN_W-1:0] used_q;
  logic [7:0]       cur_q;
  logic [7:0]       nb_q;
  logic             nb_full_q;
  logic             active_q;
  logic             accept_byte;
  logic             take;
  logic [7:0]       take_byte;

  assign byte_ready  = active_q && !nb_full_q && (fetched_q != len_q);
  assign accept_byte = byte_ready && byte_valid;
  assign take_byte   = nb_full_q ? nb_q : 8'h00;

  // A fresh byte is needed when leaving the opening pattern or a finished byte
  always_comb begin
    take = 1'b0;
    if (adv) begin
      case (seg_q)
        SEG_OPEN: take = (pos_q == 4'd7) && (len_q != '0);
        SEG_DATA: take = (pos_q == 4'd15) && (used_q != len_q);
        default:  take = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (seg_q)
      SEG_OPEN:  sym = pat_half(OPEN_PAT, pos_q[2:0]);
      SEG_DATA:  sym = data_half(cur_q[pos_q[3:1]], pos_q[0]);
      SEG_CLOSE: sym = pat_half(CLOSE_PAT, pos_q[2:0]);
      default:   sym = 1'b0;
    endcase
  end

  assign sym_last = (seg_q == SEG_CLOSE) && (pos_q == 4'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q     <= SEG_END;
      pos_q     <= '0;
      len_q     <= '0;
      fetched_q <= '0;
      used_q    <= '0;
      cur_q     <= '0;
      nb_q      <= '0;
      nb_full_q <= 1'b0;
      active_q  <= 1'b0;
    end else if (load) begin
      seg_q     <= SEG_OPEN;
      pos_q     <= '0;
      len_q     <= len_in;
      fetched_q <= '0;
      used_q    <= '0;
      nb_full_q <= 1'b0;
      active_q  <= 1'b1;
    end else begin
      if (accept_byte) begin
        nb_q      <= byte_data;
        fetched_q <= fetched_q + 1'b1;
      end
      if (accept_byte)   nb_full_q <= 1'b1;
      else if (take)     nb_full_q <= 1'b0;
      if (take) begin
        cur_q  <= take_byte;
        used_q <= used_q + 1'b1;
      end
      if (adv) begin
        case (seg_q)
          SEG_OPEN: begin
            pos_q <= '0;
            if (pos_q == 4'd7) seg_q <= (len_q == '0) ? SEG_CLOSE : SEG_DATA;
            else               pos_q <= pos_q + 1'b1;
          end
          SEG_DATA: begin
            if (pos_q == 4'd15) begin
              pos_q <= '0;
              if (used_q == len_q) seg_q <= SEG_CLOSE;
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end
          SEG_CLOSE: begin
            if (pos_q == 4'd7) begin
              seg_q    <= SEG_END;
              pos_q    <= '0;
              active_q <= 1'b0;
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end
          default: seg_q <= SEG_END;
        endcase
      end
    end
  end

  // R4
  adv_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> active_q);

endmodule

// File: rtl/rfe_shaper.sv
module rfe_shaper
  import rfe_pkg::*;
#(
  parameter int GRP_W      = 3,
  parameter int HALF_TICKS = 8,
  parameter int SLOW_REP   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [GRP_W-1:0] delay_in,
  input  logic             slow_in,
  input  logic             launch,
  input  logic             sym,
  input  logic             sym_last,
  output logic             adv,
  output logic             running,
  output logic             mod_out,
  output logic             busy
);

  localparam int SLOW_TICKS = HALF_TICKS * SLOW_REP;
  localparam int CNT_W      = $clog2(SLOW_TICKS) + 1;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [GRP_W-1:0] dly_q;
  logic             slow_q;
  logic             run_q;
  logic             mod_q;
  logic             busy_q;
  logic             emit;
  logic [CNT_W-1:0] sym_end;
  logic [CNT_W-1:0] lead_end;
  logic [CNT_W-1:0] tail_end;

  assign emit     = run_q || launch;
  assign sym_end  = slow_q ? CNT_W'(SLOW_TICKS - 1) : CNT_W'(HALF_TICKS - 1);
  assign lead_end = CNT_W'(dly_q) - 1'b1;
  assign tail_end = CNT_W'(HALF_TICKS) - CNT_W'(dly_q) - 1'b1;
  assign adv      = emit && (phase_q == PH_BODY) && (cnt_q == sym_end);
  assign running  = run_q;
  assign mod_out  = mod_q;
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_TAIL;
      cnt_q   <= '0;
      dly_q   <= '0;
      slow_q  <= 1'b0;
      run_q   <= 1'b0;
      mod_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      mod_q  <= emit && (phase_q == PH_BODY) && sym;
      busy_q <= emit;
      if (arm) begin
        phase_q <= (delay_in == '0) ? PH_BODY : PH_LEAD;
        cnt_q   <= '0;
        dly_q   <= delay_in;
        slow_q  <= slow_in;
      end else if (emit) begin
        run_q <= 1'b1;
        case (phase_q)
          PH_LEAD: begin
            if (cnt_q == lead_end) begin
              phase_q <= PH_BODY;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_BODY: begin
            if (cnt_q == sym_end) begin
              cnt_q <= '0;
              if (sym_last) phase_q <= PH_TAIL;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            if (cnt_q == tail_end) begin
              run_q <= 1'b0;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R5
  close_then_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sym_last) |=> (phase_q == PH_TAIL) && busy_q);

endmodule

// File: rtl/vtag_resp_encoder.sv
module vtag_resp_encoder #(
  parameter int TICK_W     = 32,
  parameter int LEN_W      = 6,
  parameter int HALF_TICKS = 8,
  parameter int SLOW_REP   = 4,
  parameter int TURNAROUND = 132,
  parameter int PIPE_DLY   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] now_tick,
  input  logic              frame_start,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              frame_slow,
  input  logic [TICK_W-1:0] reader_eof_tick,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  output logic              mod_out,
  output logic              busy
);

  localparam int GRP_W = $clog2(HALF_TICKS);

  logic              launch;
  logic              pending;
  logic [GRP_W-1:0]  delay_now;
  logic [TICK_W-1:0] aligned;
  logic              running;
  logic              adv;
  logic              sym;
  logic              sym_last;
  logic              idle;
  logic              accept;

  assign idle   = !pending && !running && !busy;
  assign accept = frame_start && idle;

  rfe_sched #(
    .TICK_W(TICK_W), .TURNAROUND(TURNAROUND), .PIPE_DLY(PIPE_DLY), .GRP_W(GRP_W)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .accept(accept), .eof_tick(reader_eof_tick),
    .now_tick(now_tick), .launch(launch), .pending(pending),
    .delay_now(delay_now), .aligned(aligned)
  );

  rfe_symgen #(.LEN_W(LEN_W)) u_symgen (
    .clk(clk), .rst_n(rst_n), .load(accept), .len_in(frame_len), .adv(adv),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .sym(sym), .sym_last(sym_last)
  );

  rfe_shaper #(
    .GRP_W(GRP_W), .HALF_TICKS(HALF_TICKS), .SLOW_REP(SLOW_REP)
  ) u_shaper (
    .clk(clk), .rst_n(rst_n), .arm(accept), .delay_in(delay_now),
    .slow_in(frame_slow), .launch(launch), .sym(sym), .sym_last(sym_last),
    .adv(adv), .running(running), .mod_out(mod_out), .busy(busy)
  );

  // R2
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R2
  busy_from_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pending));

  // R8
  ignore_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (pending || busy)) |=> $stable(aligned));

  // R7
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mod_out);

endmodule

// File: tb/tb_vtag_resp_encoder.sv
module tb_vtag_resp_encoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tcnt = 32'd0;
  logic        tcnt_ld = 1'b0;
  logic [31:0] tcnt_val = 32'd0;
  logic        frame_start = 1'b0;
  logic [5:0]  frame_len = '0;
  logic        frame_slow = 1'b0;
  logic [31:0] reader_eof_tick = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_ready;
  logic        mod_out;
  logic        busy;

  int total = 0;
  int bad = 0;
  int idle_mod_err = 0;
  bit finished = 0;
  bit [7:0] mem [0:63];
  int nbytes = 0;
  int fed = 0;
  bit xfer = 0;

  always #2 clk = ~clk;

  always @(posedge clk) tcnt <= tcnt_ld ? tcnt_val : tcnt + 32'd1;

  vtag_resp_encoder dut (
    .clk(clk), .rst_n(rst_n), .now_tick(tcnt), .frame_start(frame_start),
    .frame_len(frame_len), .frame_slow(frame_slow),
    .reader_eof_tick(reader_eof_tick), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_ready(byte_ready), .mod_out(mod_out),
    .busy(busy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected modulation for frame tick k
  function automatic bit exp_mod(int k, int len, bit slow, int d);
    int s = slow ? 32 : 8;
    int n = 16 + 16 * len;
    int j, si, di;
    bit b;
    if (k < d) return 0;
    j = k - d;
    si = j / s;
    if (si >= n) return 0;
    if (si < 8) return (8'h1D >> (7 - si)) & 1;
    if (si >= n - 8) return (8'hB8 >> (7 - (si - (n - 8)))) & 1;
    di = si - 8;
    b = (mem[di / 16] >> ((di % 16) / 2)) & 1;
    return (di % 2) ? b : !b;
  endfunction

  // Byte source: reports a transfer one half-cycle after its edge
  initial begin
    forever begin
      @(negedge clk);
      if (xfer) fed++;
      byte_valid = (fed < nbytes);
      byte_data = mem[fed % 64];
      #1;
      xfer = byte_valid && byte_ready;
    end
  end

  // R7 background observation
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !busy && mod_out) idle_mod_err++;
    end
  end

  task automatic run_frame(input int len, input bit slow, input int dsel, input bit intrude, input int seed);
    logic [31:0] base, eof;
    int k, mism, first_bad, waitc, stray;
    @(negedge clk);
    for (int i = 0; i < 64; i++) mem[i] = 8'((seed * 37 + i * 91 + 5) & 8'hFF);
    base = (tcnt + 32'd40) & ~32'd7;
    eof = base + 32'(dsel) - 32'd131;
    fed = 0;
    nbytes = len;
    frame_start = 1'b1;
    frame_len = 6'(len);
    frame_slow = slow;
    reader_eof_tick = eof;
    @(negedge clk);
    frame_start = 1'b0;
    waitc = 0;
    while (!busy && waitc < 300) begin
      @(negedge clk);
      waitc++;
    end
    // R2 / R10: first busy cycle shows counter one past the aligned start
    check(tcnt == base + 32'd1, $sformatf("R2 R10 start d=%0d slow=%0d", dsel, slow),
          tcnt, base + 32'd1);
    k = 0; mism = 0; first_bad = -1;
    while (busy && k < 5000) begin
      if (mod_out !== exp_mod(k, len, slow, dsel)) begin
        mism++;
        if (first_bad < 0) first_bad = k;
      end
      if (intrude && k == 20) begin
        frame_start = 1'b1;
        frame_len = 6'd2;
        reader_eof_tick = tcnt;
      end
      if (intrude && k == 21) frame_start = 1'b0;
      k++;
      @(negedge clk);
    end
    // R3 R4 R6: waveform tick by tick
    check(mism == 0, $sformatf("R3 R4 R6 waveform len=%0d d=%0d slow=%0d first_bad_tick", len, dsel, slow),
          first_bad, -1);
    // R5 R6: busy length
    check(k == (16 + 16 * len) * (slow ? 32 : 8) + 8, $sformatf("R5 R6 busy ticks len=%0d d=%0d slow=%0d", len, dsel, slow),
          k, (16 + 16 * len) * (slow ? 32 : 8) + 8);
    // R9: byte count taken
    check(fed == len, $sformatf("R9 bytes taken len=%0d", len), fed, len);
    if (intrude) begin
      stray = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (busy || byte_ready) stray++;
      end
      check(stray == 0, "R8 request during busy ignored", stray, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(mod_out == 1'b0, "R1 mod_out after reset", mod_out, 0);
    check(byte_ready == 1'b0, "R1 byte_ready after reset", byte_ready, 0);
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 4; l++)
        for (int d = 0; d < 8; d++)
          run_frame(l, s[0], d, 1'b0, s * 32 + l * 8 + d);
    run_frame(5, 1'b0, 3, 1'b1, 99);
    // R10: aligned start lies past the counter wrap
    @(negedge clk);
    tcnt_ld = 1'b1;
    tcnt_val = 32'hFFFF_FFE0;
    @(negedge clk);
    tcnt_ld = 1'b0;
    run_frame(2, 1'b0, 5, 1'b0, 7);
    check(idle_mod_err == 0, "R7 mod_out low while idle", idle_mod_err, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule